// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry

This block prepares the second operand of a data-processing instruction. It takes an operand word, a shift kind and an amount, and returns the shifted word together with the carry-out that the shift produces. In register mode, the amount is read from the low byte of a register value. The bits above that byte are ignored. Amounts of zero, amounts equal to the word width and amounts beyond the width each follow their own carry rule.

A second path is chosen by a select input. It handles shifts whose amount is encoded in the instruction as a small field. In that path the zero encodings of the right shifts mean a full-width shift, and a rotate by zero means a one-bit rotate through the carry. Both paths lead into one shared shift core. The block is purely combinational. The word width is a parameter and must be a power of two.

Top module: `shf_reg_shifter`

## Requirements
- R1: In register mode (`imm_sel_i`=0), only `amt_reg_i[7:0]` sets the amount, and bits above bit 7 have no effect on either output.
- R2: In register mode with an amount of 0, `result_o` equals `operand_i` and `carry_o` equals `carry_i`, for all four kinds. The kind codes are 0 = left logical, 1 = right logical, 2 = right arithmetic and 3 = rotate right.
- R3: A left logical shift (kind 0) by n, with 1 ≤ n < WIDTH, gives `operand_i << n` with carry-out `operand_i[WIDTH-n]`.
- R4: A left logical shift by exactly WIDTH gives 0 with carry-out `operand_i[0]`. By more than WIDTH it gives 0 with carry-out 0.
- R5: A right logical shift (kind 1) by n, with 1 ≤ n < WIDTH, fills with zeros and gives carry-out `operand_i[n-1]`.
- R6: A right logical shift by exactly WIDTH gives 0 with carry-out `operand_i[WIDTH-1]`. By more than WIDTH it gives 0 with carry-out 0.
- R7: A right arithmetic shift (kind 2) by n, with 1 ≤ n < WIDTH, fills with `operand_i[WIDTH-1]` and gives carry-out `operand_i[n-1]`. By WIDTH or more, every result bit and the carry-out equal `operand_i[WIDTH-1]`.
- R8: A rotate right (kind 3) by a nonzero amount uses only the low log2(WIDTH) bits r of the amount. If r is 0, the result is `operand_i` with carry-out `operand_i[WIDTH-1]`. Otherwise the result is the operand rotated right by r, with carry-out `operand_i[r-1]`.
- R9: In immediate mode (`imm_sel_i`=1), `imm_amt_i` is the amount. A left shift by any field value, and a rotate by a nonzero field value, behave as the same register-mode shift. A left shift by field 0 passes the operand and the incoming carry.
- R10: In immediate mode, a field value of 0 with kind 1 or kind 2 behaves as a shift by exactly WIDTH.
- R11: In immediate mode, a field value of 0 with kind 3 rotates right by one through the carry. The result is `{carry_i, operand_i[WIDTH-1:1]}` and the carry-out is `operand_i[0]`.
- R12: In immediate mode, `amt_reg_i` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | WIDTH | Word to be shifted |
| amt_reg_i | input | WIDTH | Register supplying the amount; only the low byte counts |
| shift_kind_i | input | 2 | 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right |
| carry_i | input | 1 | Current carry flag |
| imm_sel_i | input | 1 | 1 selects the immediate amount path |
| imm_amt_i | input | log2(WIDTH) | Amount field used in immediate mode |
| result_o | output | WIDTH | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench builds a second copy of the block with WIDTH=8. At that width the 8-bit amount reaches far beyond the word width, so every operand, every amount from 0 to 255, every kind and both carry values can be swept exhaustively in register mode. The zero, exact-width and beyond-width cases therefore meet every operand pattern. The WIDTH=8 copy also receives an exhaustive sweep of the immediate path, with a changing value on `amt_reg_i`. The default WIDTH=32 copy receives directed corner cases, including values that set the high bits of the amount register, and a stream of pseudo-random vectors.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SHK_LSL = 2'd0,
    SHK_LSR = 2'd1,
    SHK_ASR = 2'd2,
    SHK_ROR = 2'd3
  } shf_kind_e;

  localparam int SHF_AMT_BITS = 8;

endpackage

// File: rtl/shf_normalize.sv
module shf_normalize
  import shf_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int AMT_BITS = SHF_AMT_BITS,
  localparam int SH_W    = $clog2(WIDTH)
) (
  input  logic [1:0]          kind_i,
  input  logic [WIDTH-1:0]    amt_reg_i,
  input  logic                imm_sel_i,
  input  logic [SH_W-1:0]     imm_amt_i,
  output logic [AMT_BITS-1:0] eff_amt_o,
  output logic                rrx_sel_o,
  output logic                amt_zero_o,
  output logic                amt_full_o,
  output logic                amt_over_o
);

  localparam logic [AMT_BITS-1:0] FULL_AMT = AMT_BITS'(WIDTH);

  logic [AMT_BITS-1:0] imm_ext;
  logic                imm_is_zero;

  assign imm_ext     = AMT_BITS'(imm_amt_i);
  assign imm_is_zero = (imm_amt_i == '0);

  always_comb begin
    eff_amt_o = amt_reg_i[AMT_BITS-1:0];
    rrx_sel_o = 1'b0;
    if (imm_sel_i) begin
      eff_amt_o = imm_ext;
      unique case (shf_kind_e'(kind_i))
        SHK_LSR, SHK_ASR: if (imm_is_zero) eff_amt_o = FULL_AMT;
        SHK_ROR:          rrx_sel_o = imm_is_zero;
        default:          ;
      endcase
    end
  end

  assign amt_zero_o = (eff_amt_o == '0);
  assign amt_full_o = (eff_amt_o == FULL_AMT);
  assign amt_over_o = (eff_amt_o > FULL_AMT);

endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int AMT_BITS = SHF_AMT_BITS,
  localparam int SH_W    = $clog2(WIDTH),
  localparam int N_KIND  = 4
) (
  input  logic [WIDTH-1:0]    operand_i,
  input  logic [1:0]          kind_i,
  input  logic [AMT_BITS-1:0] amt_i,
  input  logic                carry_i,
  input  logic                rrx_sel_i,
  output logic [WIDTH-1:0]    result_o,
  output logic                carry_o
);

  localparam logic [AMT_BITS-1:0] FULL_AMT = AMT_BITS'(WIDTH);

  // Returns {carry, result}; the shifted-out bit rides in an extra position.
  function automatic logic [WIDTH:0] shift_word(
    input logic [1:0]          k,
    input logic [WIDTH-1:0]    v,
    input logic [AMT_BITS-1:0] a,
    input logic                ci
  );
    logic [WIDTH:0]        ext;
    logic signed [WIDTH:0] sx;
    logic [AMT_BITS-1:0]   sat;
    logic [2*WIDTH-1:0]    dbl;
    if (a == '0) return {ci, v};
    unique case (shf_kind_e'(k))
      SHK_LSL: begin
        ext = {1'b0, v} << a;
        return ext;
      end
      SHK_LSR: begin
        ext = {v, 1'b0} >> a;
        return {ext[0], ext[WIDTH:1]};
      end
      SHK_ASR: begin
        sat = (a > FULL_AMT) ? FULL_AMT : a;
        sx  = {v, 1'b0};
        ext = sx >>> sat;
        return {ext[0], ext[WIDTH:1]};
      end
      default: begin
        dbl = {v, v} >> a[SH_W-1:0];
        return {dbl[WIDTH-1], dbl[WIDTH-1:0]};
      end
    endcase
  endfunction

  function automatic logic [WIDTH:0] rotate_through_carry(
    input logic [WIDTH-1:0] v,
    input logic             ci
  );
    return {v[0], ci, v[WIDTH-1:1]};
  endfunction

  logic [WIDTH:0] cand [N_KIND];
  logic [WIDTH:0] rrx_word;
  logic [WIDTH:0] picked;

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    assign cand[k] = shift_word(2'(k), operand_i, amt_i, carry_i);
  end

  assign rrx_word = rotate_through_carry(operand_i, carry_i);
  assign picked   = rrx_sel_i ? rrx_word : cand[kind_i];
  assign result_o = picked[WIDTH-1:0];
  assign carry_o  = picked[WIDTH];

endmodule

// File: rtl/shf_reg_shifter.sv
module shf_reg_shifter
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SH_W = $clog2(WIDTH),
  localparam int AMT_BITS = SHF_AMT_BITS
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [WIDTH-1:0] amt_reg_i,
  input  logic [1:0]       shift_kind_i,
  input  logic             carry_i,
  input  logic             imm_sel_i,
  input  logic [SH_W-1:0]  imm_amt_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);

  logic [AMT_BITS-1:0] eff_amt;
  logic                rrx_sel;
  logic                amt_zero;
  logic                amt_full;
  logic                amt_over;

  shf_normalize #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_norm (
    .kind_i     (shift_kind_i),
    .amt_reg_i  (amt_reg_i),
    .imm_sel_i  (imm_sel_i),
    .imm_amt_i  (imm_amt_i),
    .eff_amt_o  (eff_amt),
    .rrx_sel_o  (rrx_sel),
    .amt_zero_o (amt_zero),
    .amt_full_o (amt_full),
    .amt_over_o (amt_over)
  );

  shf_core #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_core (
    .operand_i (operand_i),
    .kind_i    (shift_kind_i),
    .amt_i     (eff_amt),
    .carry_i   (carry_i),
    .rrx_sel_i (rrx_sel),
    .result_o  (result_o),
    .carry_o   (carry_o)
  );

endmodule

// File: rtl/shf_reg_shifter_chk.sv
module shf_reg_shifter_chk
  import shf_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] operand_i,
  input logic [1:0]       shift_kind_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             rrx_sel,
  input logic             amt_zero,
  input logic             amt_full,
  input logic             amt_over
);

  logic sign_bit;
  assign sign_bit = operand_i[WIDTH-1];

  always_comb begin
    if (amt_zero && !rrx_sel) begin
      assert_zero_pass_R2: assert (result_o == operand_i && carry_o == carry_i)
        else $error("zero amount altered operand or carry");
    end
    if (amt_over && shift_kind_i inside {SHK_LSL, SHK_LSR}) begin
      assert_logical_over_R4: assert (result_o == '0 && !carry_o)
        else $error("logical shift beyond width not cleared");
    end
    if (amt_full && shift_kind_i == SHK_LSR) begin
      assert_lsr_full_R6: assert (result_o == '0 && carry_o == sign_bit)
        else $error("right logical full-width rule broken");
    end
    if ((amt_full || amt_over) && shift_kind_i == SHK_ASR) begin
      assert_asr_saturate_R7: assert (result_o == {WIDTH{sign_bit}} && carry_o == sign_bit)
        else $error("arithmetic saturation rule broken");
    end
    if (rrx_sel) begin
      assert_rrx_carry_R11: assert (carry_o == operand_i[0] && result_o[WIDTH-1] == carry_i)
        else $error("rotate through carry broken");
    end
  end

endmodule

bind shf_reg_shifter shf_reg_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .operand_i    (operand_i),
  .shift_kind_i (shift_kind_i),
  .carry_i      (carry_i),
  .result_o     (result_o),
  .carry_o      (carry_o),
  .rrx_sel      (rrx_sel),
  .amt_zero     (amt_zero),
  .amt_full     (amt_full),
  .amt_over     (amt_over)
);

// File: tb/test_shf_reg_shifter.sv
module test_shf_reg_shifter;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // default-width instance
  logic [31:0] op32, amt32, res32;
  logic [1:0]  kind32;
  logic        ci32, imm32, co32;
  logic [4:0]  iamt32;

  shf_reg_shifter i_shf_reg_shifter (
    .operand_i (op32), .amt_reg_i (amt32), .shift_kind_i (kind32),
    .carry_i (ci32), .imm_sel_i (imm32), .imm_amt_i (iamt32),
    .result_o (res32), .carry_o (co32)
  );

  // narrow instance for exhaustive sweeps
  logic [7:0] op8, amt8, res8;
  logic [1:0] kind8;
  logic       ci8, imm8, co8;
  logic [2:0] iamt8;

  shf_reg_shifter #(.WIDTH(8)) i_shf_reg_shifter_w8 (
    .operand_i (op8), .amt_reg_i (amt8), .shift_kind_i (kind8),
    .carry_i (ci8), .imm_sel_i (imm8), .imm_amt_i (iamt8),
    .result_o (res8), .carry_o (co8)
  );

  // Bitwise reference: each result bit is picked from its source position.
  task automatic ref_shift(input int w, input int kind, input logic [31:0] v,
                           input int a, input logic ci,
                           output logic [31:0] r, output logic c);
    r = '0;
    if (a == 0) begin
      r = v; c = ci;
      return;
    end
    case (kind)
      0: begin
        for (int i = 0; i < w; i++) if (i - a >= 0) r[i] = v[i-a];
        c = (a <= w) ? v[w-a] : 1'b0;
      end
      1: begin
        for (int i = 0; i < w; i++) if (i + a < w) r[i] = v[i+a];
        c = (a <= w) ? v[a-1] : 1'b0;
      end
      2: begin
        for (int i = 0; i < w; i++) r[i] = v[(i + a < w) ? i + a : w - 1];
        c = v[((a < w) ? a : w) - 1];
      end
      default: begin
        int rr;
        rr = a % w;
        for (int i = 0; i < w; i++) r[i] = v[(i + rr) % w];
        c = v[(rr + w - 1) % w];
      end
    endcase
  endtask

  task automatic ref_imm(input int w, input int kind, input logic [31:0] v,
                         input int f, input logic ci,
                         output logic [31:0] r, output logic c);
    if (kind == 3 && f == 0) begin
      r = (v >> 1) | (32'(ci) << (w - 1));
      c = v[0];
    end else if ((kind == 1 || kind == 2) && f == 0) begin
      ref_shift(w, kind, v, w, ci, r, c);
    end else begin
      ref_shift(w, kind, v, f, ci, r, c);
    end
  endtask

  task automatic check(input string tag, input logic [31:0] got_r, input logic got_c,
                       input logic [31:0] exp_r, input logic exp_c);
    n_tests++;
    if (got_r !== exp_r || got_c !== exp_c) begin
      n_fail++;
      if (n_fail < 20)
        $display("FAIL %s: got result=%h carry=%b, expected result=%h carry=%b",
                 tag, got_r, got_c, exp_r, exp_c);
    end
  endtask

  function automatic string reg_tag(int w, int kind, int a);
    if (a == 0) return "R2";
    case (kind)
      0: return (a < w) ? "R3" : "R4";
      1: return (a < w) ? "R5" : "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic drive32(input logic [31:0] v, input logic [31:0] a, input int k,
                         input logic ci);
    op32 = v; amt32 = a; kind32 = 2'(k); ci32 = ci; imm32 = 1'b0; iamt32 = '0;
    #1;
  endtask

  initial begin
    logic [31:0] er;
    logic        ec;

    // quiescent state: all inputs zero
    op32 = '0; amt32 = '0; kind32 = '0; ci32 = 1'b0; imm32 = 1'b0; iamt32 = '0;
    op8 = '0; amt8 = '0; kind8 = '0; ci8 = 1'b0; imm8 = 1'b0; iamt8 = '0;
    #1;
    check("R2 idle", res32, co32, 32'h0, 1'b0);

    // directed corners on the 32-bit copy
    drive32(32'h0000_0001, 32'hFFFF_FF04, 0, 1'b0);
    check("R1 high amount bits ignored", res32, co32, 32'h0000_0010, 1'b0);
    drive32(32'h1234_5678, 32'h1234_5600, 1, 1'b1);
    check("R1 R2 low byte zero", res32, co32, 32'h1234_5678, 1'b1);
    drive32(32'hC000_0001, 32'd1, 0, 1'b0);
    check("R3 lsl 1", res32, co32, 32'h8000_0002, 1'b1);
    drive32(32'hC000_0001, 32'd32, 0, 1'b0);
    check("R4 lsl 32", res32, co32, 32'h0, 1'b1);
    drive32(32'hC000_0001, 32'd33, 0, 1'b1);
    check("R4 lsl 33", res32, co32, 32'h0, 1'b0);
    drive32(32'h8000_0003, 32'd2, 1, 1'b0);
    check("R5 lsr 2", res32, co32, 32'h2000_0000, 1'b1);
    drive32(32'h8000_0000, 32'd32, 1, 1'b0);
    check("R6 lsr 32", res32, co32, 32'h0, 1'b1);
    drive32(32'h8000_0000, 32'd200, 1, 1'b1);
    check("R6 lsr 200", res32, co32, 32'h0, 1'b0);
    drive32(32'h8000_0010, 32'd4, 2, 1'b0);
    check("R7 asr 4", res32, co32, 32'hF800_0001, 1'b0);
    drive32(32'h8000_0000, 32'd40, 2, 1'b0);
    check("R7 asr 40", res32, co32, 32'hFFFF_FFFF, 1'b1);
    drive32(32'h8000_0001, 32'd32, 3, 1'b0);
    check("R8 ror 32", res32, co32, 32'h8000_0001, 1'b1);
    drive32(32'h0000_0013, 32'd36, 3, 1'b0);
    check("R8 ror 36", res32, co32, 32'h3000_0001, 1'b0);

    // immediate path on the 32-bit copy
    op32 = 32'h8000_0001; kind32 = 2'd3; ci32 = 1'b1; imm32 = 1'b1; iamt32 = 5'd0;
    amt32 = 32'd5; #1;
    check("R11 rrx", res32, co32, 32'hC000_0000, 1'b1);
    kind32 = 2'd1; #1;
    check("R10 lsr #0", res32, co32, 32'h0, 1'b1);

    // pseudo-random vectors on the 32-bit copy
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] v, a;
      int          k;
      logic        ci, sel;
      v = $urandom; a = $urandom; k = $urandom_range(0, 3);
      ci = 1'($urandom); sel = 1'($urandom);
      op32 = v; amt32 = a; kind32 = 2'(k); ci32 = ci; imm32 = sel;
      iamt32 = a[12:8];
      #1;
      if (sel) begin
        ref_imm(32, k, v, int'(a[12:8]), ci, er, ec);
        check((k == 3 && a[12:8] == 0) ? "R11 rand" : "R9 R12 rand", res32, co32, er, ec);
      end else begin
        ref_shift(32, k, v, int'(a[7:0]), ci, er, ec);
        check({"R1 ", reg_tag(32, k, int'(a[7:0]))}, res32, co32, er, ec);
      end
    end

    // exhaustive register-mode sweep on the 8-bit copy
    imm8 = 1'b0; iamt8 = '0;
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a++)
          for (int v = 0; v < 256; v++) begin
            op8 = 8'(v); amt8 = 8'(a); kind8 = 2'(k); ci8 = 1'(c);
            #1;
            ref_shift(8, k, 32'(v), a, 1'(c), er, ec);
            check(reg_tag(8, k, a), 32'(res8), co8, er, ec);
          end

    // exhaustive immediate-mode sweep on the 8-bit copy, register input churned
    imm8 = 1'b1;
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 2; c++)
        for (int f = 0; f < 8; f++)
          for (int v = 0; v < 256; v++) begin
            op8 = 8'(v); iamt8 = 3'(f); kind8 = 2'(k); ci8 = 1'(c);
            amt8 = 8'(v * 7 + f + 1);
            #1;
            ref_imm(8, k, 32'(v), f, 1'(c), er, ec);
            if (f == 0 && k == 3)
              check("R11 R12", 32'(res8), co8, er, ec);
            else if (f == 0 && (k == 1 || k == 2))
              check("R10 R12", 32'(res8), co8, er, ec);
            else
              check("R9 R12", 32'(res8), co8, er, ec);
          end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule